// File: doc/BRIEF.md
# Prioritized Chip-Select Decoder

This block turns the upper bits of a 16-bit bus address into four external chip selects for a small 8-bit controller: a program-memory select, an I/O select and two general-purpose selects. Four on-chip resources (register file, RAM, boot ROM, EEPROM) report their own address hits. Any such hit outranks every external device. Among the external selects, the I/O window always wins. A single control bit decides whether the program select sits above or below the two general-purpose selects.

Each select has its own stretch count. When a bus cycle starts and an external select wins, the block raises a stretch request for exactly that many clocks, so that a slow device can hold the cycle. Software sets the enables, polarities, window sizes, base pages, the priority order and the stretch counts through a plain register-write port. The reset values depend on the operating-mode inputs. The selects are decoded combinationally from the address while it is valid; the stretch request is registered. Only the four upper address bits take part in decoding, so only they enter the block. All pins are plain level signals: the block neither accepts nor produces a data stream, so there is no back-pressure.

Top module: `csel_decoder`

## Requirements
- R1: While any of hit_reg, hit_ram, hit_boot or hit_eep is high, all external selects sit at their inactive level, and a cycle started then raises no stretch request.
- R2: The I/O select wins ahead of the program and general-purpose selects. With control bit 3 = 0 it covers page 1 (0x1000–0x1FFF). With control bit 3 = 1 it covers pages 0–1 (0x0000–0x1FFF). Control bit 1 enables it.
- R3: With control bit 6 = 0, the order below the I/O select is program, then general-purpose 1, then general-purpose 2.
- R4: With control bit 6 = 1, the order below the I/O select is general-purpose 1, then general-purpose 2, then program.
- R5: The program select covers 0x8000–0xFFFF, is enabled by control bit 0, and is always active low.
- R6: General-purpose select g (register 1+g, enabled by control bit 4+g) matches when addr_hi shifted right by k equals its base shifted right by k. Bits [3:0] of its register hold the base page. Bits [5:4] hold k, which sets a window of 4 KB·2^k. Bit 6 sets the polarity (1 = active high).
- R7: At most one select is active at a time. A select that is disabled, unmatched or outranked, or any select while addr_valid is low, sits at its inactive level. Control bit 2 sets the I/O select polarity (1 = active high).
- R8: Reset values in normal mode (mode_special = 0): the program select is enabled only when vec_internal is 0, and its stretch count is 1. In special mode: the program select is enabled and its stretch count is 0. All other enables, polarities, bases, sizes, counts and bit 6 reset to 0.
- R9: On a clock edge with cyc_start high and stretch low, the winning select's count N is loaded. The stretch output is then high for exactly N clocks. Register 3 holds the counts: [1:0] program, [3:2] I/O, [5:4] general-purpose 1, [7:6] general-purpose 2. N is 0 when no external select wins.
- R10: cyc_start is ignored while stretch is high; it neither reloads nor lengthens the request.
- R11: A write with wr_en high to wr_addr 0 (control), 1 or 2 (general-purpose) or 3 (stretch counts) takes effect at that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_special | input | 1 | 1 = special test mode, 0 = normal expanded mode (read during reset) |
| vec_internal | input | 1 | An internal memory answers at the reset vector (read during reset) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index |
| wr_data | input | 8 | Register write data |
| addr_valid | input | 1 | Address bus holds a valid address |
| cyc_start | input | 1 | First clock of a bus cycle |
| addr_hi | input | 4 | Address bits 15:12 |
| hit_reg | input | 1 | On-chip register file claims the address |
| hit_ram | input | 1 | On-chip RAM claims the address |
| hit_boot | input | 1 | Boot ROM claims the address |
| hit_eep | input | 1 | On-chip EEPROM claims the address |
| prog_cs_n | output | 1 | Program select, active low |
| io_cs | output | 1 | I/O select, programmable polarity |
| gp_cs | output | 2 | General-purpose selects, programmable polarity each |
| stretch | output | 1 | Bus-stretch request |

## Verification
Every one of the 16 pages is applied under four register setups. The setups include nested and overlapping general-purpose windows, both priority orders, both I/O sizes, mixed polarities and all selects disabled. Each page is tried with no internal hit, with each internal hit alone, and with addr_valid low. The patterns separate window arithmetic from priority: an overlap shows the ordering, and a lone match shows the window edge. Stretch lengths are measured for a count of 0, 1, 2 and 3, for an internal win, for a nested window where the lower-ranked select wins, and with cyc_start held during a stretch. The three reset flavours are each checked at the ports.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int PAGE_W  = 4;
  localparam int GP_CNT  = 2;
  localparam int SZ_W    = 2;
  localparam int ST_W    = 2;
  localparam int REG_CNT = 2 + GP_CNT;
  localparam int RA_W    = $clog2(REG_CNT);
  localparam int GRANT_W = 2 + GP_CNT;

  // grant vector positions
  localparam int G_PROG = 0;
  localparam int G_IO   = 1;
  localparam int G_GP0  = 2;

  typedef struct packed {
    logic                          prog_en;
    logic                          io_en;
    logic                          io_pol;
    logic                          io_size;
    logic                          swap;
    logic [GP_CNT-1:0]             gp_en;
    logic [GP_CNT-1:0]             gp_pol;
    logic [GP_CNT-1:0][PAGE_W-1:0] gp_base;
    logic [GP_CNT-1:0][SZ_W-1:0]   gp_size;
    logic [ST_W-1:0]               st_prog;
    logic [ST_W-1:0]               st_io;
    logic [GP_CNT-1:0][ST_W-1:0]   st_gp;
  } csel_cfg_t;
endpackage

// File: rtl/csel_regs.sv
`timescale 1ns/1ps
module csel_regs
  import csel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_special,
  input  logic              vec_internal,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output csel_cfg_t         cfg
);
  localparam int A_CTRL = 0;
  localparam int A_GP   = 1;
  localparam int A_ST   = REG_CNT - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg         <= '0;
      cfg.prog_en <= mode_special | ~vec_internal;
      cfg.st_prog <= mode_special ? '0 : ST_W'(1);
    end else if (wr_en) begin
      if (wr_addr == RA_W'(A_CTRL)) begin
        cfg.prog_en <= wr_data[0];
        cfg.io_en   <= wr_data[1];
        cfg.io_pol  <= wr_data[2];
        cfg.io_size <= wr_data[3];
        cfg.swap    <= wr_data[6];
        for (int g = 0; g < GP_CNT; g++) cfg.gp_en[g] <= wr_data[4+g];
      end else if (wr_addr == RA_W'(A_ST)) begin
        cfg.st_prog <= wr_data[ST_W-1:0];
        cfg.st_io   <= wr_data[2*ST_W-1:ST_W];
        for (int g = 0; g < GP_CNT; g++)
          cfg.st_gp[g] <= wr_data[(2+g)*ST_W +: ST_W];
      end else begin
        for (int g = 0; g < GP_CNT; g++) begin
          if (wr_addr == RA_W'(A_GP + g)) begin
            cfg.gp_base[g] <= wr_data[PAGE_W-1:0];
            cfg.gp_size[g] <= wr_data[PAGE_W +: SZ_W];
            cfg.gp_pol[g]  <= wr_data[PAGE_W+SZ_W];
          end
        end
      end
    end
  end

  // R11
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_W'(A_CTRL)) |=> (cfg.swap == $past(wr_data[6])));
endmodule

// File: rtl/csel_window.sv
`timescale 1ns/1ps
module csel_window
  import csel_pkg::*;
(
  input  logic              enable,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] base,
  input  logic [SZ_W-1:0]   size_code,
  output logic              hit
);
  logic [PAGE_W-1:0] keep_mask;

  always_comb begin
    keep_mask = {PAGE_W{1'b1}} << size_code;
    hit       = enable && (((page ^ base) & keep_mask) == '0);
  end
endmodule

// File: rtl/csel_arbiter.sv
`timescale 1ns/1ps
module csel_arbiter
  import csel_pkg::*;
(
  input  logic               valid,
  input  logic               any_int,
  input  logic               io_hit,
  input  logic               prog_hit,
  input  logic [GP_CNT-1:0]  gp_hit,
  input  logic               swap,
  output logic [GRANT_W-1:0] grant
);
  logic [GP_CNT-1:0] gp_first;

  always_comb begin
    gp_first = '0;
    for (int g = GP_CNT - 1; g >= 0; g--) begin
      if (gp_hit[g]) gp_first = GP_CNT'(1) << g;
    end
  end

  always_comb begin
    grant = '0;
    if (!valid || any_int) begin
      grant = '0;
    end else if (io_hit) begin
      grant[G_IO] = 1'b1;
    end else if (!swap && prog_hit) begin
      grant[G_PROG] = 1'b1;
    end else if (|gp_hit) begin
      grant[G_GP0 +: GP_CNT] = gp_first;
    end else if (prog_hit) begin
      grant[G_PROG] = 1'b1;
    end
  end
endmodule

// File: rtl/csel_stretch.sv
`timescale 1ns/1ps
module csel_stretch
  import csel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ST_W-1:0] load_val,
  output logic            busy
);
  logic [ST_W-1:0] cnt_q;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (busy)  cnt_q <= cnt_q - 1'b1;
    else if (start) cnt_q <= load_val;
  end

  // R9
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R10
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/csel_decoder.sv
`timescale 1ns/1ps
module csel_decoder
  import csel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_special,
  input  logic              vec_internal,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              addr_valid,
  input  logic              cyc_start,
  input  logic [PAGE_W-1:0] addr_hi,
  input  logic              hit_reg,
  input  logic              hit_ram,
  input  logic              hit_boot,
  input  logic              hit_eep,
  output logic              prog_cs_n,
  output logic              io_cs,
  output logic [GP_CNT-1:0] gp_cs,
  output logic              stretch
);
  csel_cfg_t          cfg;
  logic               any_int;
  logic               io_hit;
  logic               prog_hit;
  logic [GP_CNT-1:0]  gp_hit;
  logic [GRANT_W-1:0] grant;
  logic [ST_W-1:0]    load_val;
  logic               busy;

  csel_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_special (mode_special),
    .vec_internal (vec_internal),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .cfg          (cfg)
  );

  assign any_int  = hit_reg | hit_ram | hit_boot | hit_eep;
  assign prog_hit = cfg.prog_en && addr_hi[PAGE_W-1];
  assign io_hit   = cfg.io_en &&
                    (cfg.io_size ? (addr_hi[PAGE_W-1:1] == '0) : (addr_hi == PAGE_W'(1)));

  for (genvar g = 0; g < GP_CNT; g++) begin : gen_gp
    csel_window u_win (
      .enable    (cfg.gp_en[g]),
      .page      (addr_hi),
      .base      (cfg.gp_base[g]),
      .size_code (cfg.gp_size[g]),
      .hit       (gp_hit[g])
    );
    assign gp_cs[g] = cfg.gp_pol[g] ? grant[G_GP0+g] : ~grant[G_GP0+g];
  end

  csel_arbiter u_arb (
    .valid    (addr_valid),
    .any_int  (any_int),
    .io_hit   (io_hit),
    .prog_hit (prog_hit),
    .gp_hit   (gp_hit),
    .swap     (cfg.swap),
    .grant    (grant)
  );

  always_comb begin
    load_val = '0;
    if (grant[G_PROG]) load_val = cfg.st_prog;
    if (grant[G_IO])   load_val = cfg.st_io;
    for (int g = 0; g < GP_CNT; g++) begin
      if (grant[G_GP0+g]) load_val = cfg.st_gp[g];
    end
  end

  csel_stretch u_str (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cyc_start),
    .load_val (load_val),
    .busy     (busy)
  );

  assign prog_cs_n = ~grant[G_PROG];
  assign io_cs     = cfg.io_pol ? grant[G_IO] : ~grant[G_IO];
  assign stretch   = busy;

  // R1
  int_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_int |-> (grant == '0));

  // R1
  int_no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !stretch && any_int) |=> !stretch);

  // R7
  single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R5
  prog_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_cs_n |-> addr_hi[PAGE_W-1]);

  // R2
  io_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_cs == cfg.io_pol) && !cfg.io_size) |-> (addr_hi == PAGE_W'(1)));
endmodule

// File: tb/test_csel_decoder.sv
`timescale 1ns/1ps
module test_csel_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_special = 1'b0;
  logic       vec_internal = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       addr_valid = 1'b0;
  logic       cyc_start = 1'b0;
  logic [3:0] addr_hi = '0;
  logic [3:0] hits = '0;
  logic       prog_cs_n, io_cs, stretch;
  logic [1:0] gp_cs;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0] m_ctrl;
  logic [7:0] m_gp [2];
  logic [7:0] m_st;

  always #10 clk = ~clk;

  csel_decoder i_csel_decoder (
    .clk(clk), .rst_n(rst_n), .mode_special(mode_special), .vec_internal(vec_internal),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .addr_valid(addr_valid), .cyc_start(cyc_start), .addr_hi(addr_hi),
    .hit_reg(hits[0]), .hit_ram(hits[1]), .hit_boot(hits[2]), .hit_eep(hits[3]),
    .prog_cs_n(prog_cs_n), .io_cs(io_cs), .gp_cs(gp_cs), .stretch(stretch)
  );

  initial begin
    #4000000;
    miscompares++;
    vectors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // active vector: [0] program, [1] I/O, [2] gp1, [3] gp2
  function automatic logic [3:0] model(input logic [3:0] pg, input logic [3:0] h, input logic v);
    logic io_m, p_m;
    logic [1:0] g_m;
    io_m = m_ctrl[1] && (m_ctrl[3] ? (pg < 4'd2) : (pg == 4'd1));
    p_m  = m_ctrl[0] && (pg >= 4'd8);
    for (int g = 0; g < 2; g++)
      g_m[g] = m_ctrl[4+g] && ((pg >> m_gp[g][5:4]) == (m_gp[g][3:0] >> m_gp[g][5:4]));
    if (!v || h != 0) return 4'd0;
    if (io_m) return 4'b0010;
    if (!m_ctrl[6]) begin
      if (p_m) return 4'b0001;
      if (g_m[0]) return 4'b0100;
      if (g_m[1]) return 4'b1000;
    end else begin
      if (g_m[0]) return 4'b0100;
      if (g_m[1]) return 4'b1000;
      if (p_m) return 4'b0001;
    end
    return 4'd0;
  endfunction

  function automatic logic [3:0] port_image(input logic [3:0] act);
    logic [3:0] r;
    r[3] = ~act[0];
    r[2] = m_ctrl[2] ? act[1] : ~act[1];
    r[1] = m_gp[1][6] ? act[3] : ~act[3];
    r[0] = m_gp[0][6] ? act[2] : ~act[2];
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] pg, input logic [3:0] h, input logic v);
    logic [3:0] e;
    logic p_m, g_any, io_m;
    if (h != 0) return "R1";
    if (!v) return "R7";
    e     = model(pg, h, v);
    io_m  = m_ctrl[1] && (m_ctrl[3] ? (pg < 4'd2) : (pg == 4'd1));
    p_m   = m_ctrl[0] && (pg >= 4'd8);
    g_any = 1'b0;
    for (int g = 0; g < 2; g++)
      if (m_ctrl[4+g] && ((pg >> m_gp[g][5:4]) == (m_gp[g][3:0] >> m_gp[g][5:4]))) g_any = 1'b1;
    if (!io_m && p_m && g_any) return m_ctrl[6] ? "R4" : "R3";
    if (e == 4'b0010) return "R2";
    if (e == 4'b0001) return "R5";
    if (e[3:2] != 0) return "R6";
    return "R7";
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 0) m_ctrl = d;
    else if (a == 3) m_st = d;
    else m_gp[a-1] = d;
  endtask

  task automatic apply(input logic [3:0] pg, input logic [3:0] h, input logic v, input string tag);
    @(negedge clk);
    addr_hi = pg; hits = h; addr_valid = v; cyc_start = 1'b0;
    #2;
    chk(tag, {28'd0, prog_cs_n, io_cs, gp_cs}, {28'd0, port_image(model(pg, h, v))});
  endtask

  task automatic measure(input logic [3:0] pg, input logic [3:0] h, input int hold, output int n);
    @(negedge clk);
    addr_hi = pg; hits = h; addr_valid = 1'b1; cyc_start = 1'b1;
    @(negedge clk);
    n = 0;
    if (hold == 0) cyc_start = 1'b0;
    while (stretch && n < 8) begin
      n++;
      if (n >= hold) cyc_start = 1'b0;
      @(negedge clk);
    end
    cyc_start = 1'b0;
  endtask

  task automatic do_reset(input logic sp, input logic vi);
    @(negedge clk);
    rst_n = 1'b0; mode_special = sp; vec_internal = vi;
    addr_valid = 1'b0; cyc_start = 1'b0; hits = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_ctrl = {7'd0, sp | ~vi};
    m_gp[0] = 8'd0; m_gp[1] = 8'd0;
    m_st = sp ? 8'd0 : 8'd1;
  endtask

  initial begin
    int n;
    logic [7:0] cfg_tab [4][3];
    cfg_tab[0] = '{8'h33, 8'h68, 8'h1A};
    cfg_tab[1] = '{8'h7F, 8'h30, 8'h4C};
    cfg_tab[2] = '{8'h04, 8'h40, 8'h40};
    cfg_tab[3] = '{8'h61, 8'h00, 8'h6F};

    // R8 normal mode, no internal vector memory
    do_reset(1'b0, 1'b0);
    #2;
    chk("R8 stretch idle after reset", {31'd0, stretch}, 32'd0);
    for (int p = 0; p < 16; p++) apply(4'(p), 4'd0, 1'b1, "R8");
    measure(4'd8, 4'd0, 0, n);
    chk("R8 normal program stretch", n, 1);

    // R8 special mode
    do_reset(1'b1, 1'b1);
    for (int p = 0; p < 16; p++) apply(4'(p), 4'd0, 1'b1, "R8");
    measure(4'd8, 4'd0, 0, n);
    chk("R8 special program stretch", n, 0);

    // R8 normal mode with internal vector memory
    do_reset(1'b0, 1'b1);
    for (int p = 0; p < 16; p++) apply(4'(p), 4'd0, 1'b1, "R8");
    measure(4'd8, 4'd0, 0, n);
    chk("R8 disabled program no stretch", n, 0);
    wr(2'd0, 8'h01);
    apply(4'd9, 4'd0, 1'b1, "R11");
    measure(4'd8, 4'd0, 0, n);
    chk("R8 default count after enable", n, 1);

    // R1..R7 sweeps
    for (int c = 0; c < 4; c++) begin
      wr(2'd0, cfg_tab[c][0]);
      wr(2'd1, cfg_tab[c][1]);
      wr(2'd2, cfg_tab[c][2]);
      for (int p = 0; p < 16; p++) begin
        for (int hi = 0; hi < 5; hi++) begin
          logic [3:0] h;
          h = (hi == 0) ? 4'd0 : 4'(1 << (hi - 1));
          apply(4'(p), h, 1'b1, tag_of(4'(p), h, 1'b1));
        end
        apply(4'(p), 4'hF, 1'b1, "R1");
        apply(4'(p), 4'd0, 1'b0, "R7");
      end
    end

    // R9 stretch lengths
    wr(2'd0, 8'h32);
    wr(2'd1, 8'h08);
    wr(2'd2, 8'h1A);
    wr(2'd3, 8'hE4);
    measure(4'd1, 4'd0, 0, n);  chk("R9 io count 1", n, 1);
    measure(4'd8, 4'd0, 0, n);  chk("R9 gp1 count 2", n, 2);
    measure(4'd10, 4'd0, 0, n); chk("R9 gp2 count 3", n, 3);
    measure(4'd11, 4'd0, 0, n); chk("R9 gp2 upper page count 3", n, 3);
    measure(4'd4, 4'd0, 0, n);  chk("R9 no select count 0", n, 0);
    measure(4'd1, 4'd2, 0, n);  chk("R1 R9 internal win count 0", n, 0);
    wr(2'd0, 8'h33);
    measure(4'd10, 4'd0, 0, n); chk("R3 R9 program wins count 0", n, 0);
    wr(2'd0, 8'h73);
    measure(4'd10, 4'd0, 0, n); chk("R4 R9 gp2 wins count 3", n, 3);
    measure(4'd12, 4'd0, 0, n); chk("R4 R9 program count 0", n, 0);

    // R10 start held during stretch
    measure(4'd10, 4'd0, 2, n); chk("R10 held start ignored", n, 3);
    #2;
    chk("R10 stretch released", {31'd0, stretch}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule